// File: doc/BRIEF.md
# Gated-Clock Synchronous Serial Transmitter

This block takes a parallel word and sends it out on a single data line, least significant bit first. Next to the data it drives a clock line that moves only while data bits are on the wire, plus two framing lines for a synchronous receiver. The first framing line marks the whole frame, and its active level is selectable. The second framing line is a one-bit-long strobe that is high during the first bit only. The bit rate is set by a half-bit enable tick that the surrounding logic supplies. Each bit cell lasts two ticks: a launch half and a capture half.

Two configuration inputs set the pin behaviour. `sync_en_i` selects synchronous operation, and `clk_sel_i` is a 2-bit clock-source code. With synchronous operation off, code 11 selects expansion mode. In this mode the clock idles high, data is launched on the falling edge, and the receiver samples on the rising edge. With synchronous operation on, the clock idle level and the active edge are set by their own inputs, and code 00 turns the clock output off. The configuration is expected to stay still while a frame is in flight.

A word is accepted by pulsing `load_i` while the block is idle. The first tick after that starts the LSB. The tick that ends the capture half of the MSB closes the frame. All pins come from registers, so every pin change appears one clock after the edge that caused it.

Top module: `sync_frame_tx`

## Requirements
- R1: Data leaves on `sdata_o` least significant bit first. Each bit is held for two tick periods. Outside a frame, `sdata_o` is 1.
- R2: `sclk_o` rests at the idle level of the selected mode whenever no data bit is being sent, including the wait between load and the first tick.
- R3: Expansion mode is `sync_en_i`=0 with `clk_sel_i`=2'b11. In this mode `sclk_o` idles at 1, is 0 in the launch half of every bit and 1 in the capture half, so each bit is valid on the rising edge.
- R4: Synchronous mode is `sync_en_i`=1 with `clk_sel_i` not equal to 2'b00. In this mode `sclk_o` idles at `clk_idle_hi_i`. With `clk_rise_act_i`=1 it is 0 in the launch half and 1 in the capture half. With `clk_rise_act_i`=0 it is 1 in the launch half and 0 in the capture half.
- R5: With `sync_en_i`=1 and `clk_sel_i`=2'b00, `sclk_o` stays at `clk_idle_hi_i` for the whole frame, while data still shifts out.
- R6: With `sync_en_i`=0 and `clk_sel_i` not equal to 2'b11, `sclk_o` stays at 1 for the whole frame.
- R7: When `sync_en_i`=1, `rts_o` equals `rts_hi_i` from the LSB launch until the tick that ends the MSB capture half, and equals the inverse of `rts_hi_i` at all other times. When `sync_en_i`=0, `rts_o` always equals the inverse of `rts_hi_i`.
- R8: When `sync_en_i`=1, `strobe_o` is 1 through both halves of the first bit and 0 at all other times. When `sync_en_i`=0, `strobe_o` is always 0.
- R9: `busy_o` rises after an accepted load and falls with the frame-ending tick. A `load_i` pulse while busy is ignored, and the word in flight is sent unchanged.
- R10: Ticks while idle have no effect. The first tick after a load starts the LSB. Each pin reflects a tick or a load two clock edges after the cycle in which the input was high.
- R11: The word width is the parameter `WIDTH` (default 8, minimum 2). A frame is exactly 2*`WIDTH` ticks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick_i | input | 1 | Half-bit enable, one cycle wide |
| load_i | input | 1 | Request to send `data_i` |
| data_i | input | WIDTH | Word to transmit |
| sync_en_i | input | 1 | 1 = synchronous mode |
| clk_sel_i | input | 2 | Clock-source code (11 = expansion when not synchronous, 00 = clock off when synchronous) |
| clk_idle_hi_i | input | 1 | Idle clock level in synchronous mode |
| clk_rise_act_i | input | 1 | 1 = rising active edge in synchronous mode |
| rts_hi_i | input | 1 | Active level of `rts_o` |
| sdata_o | output | 1 | Serial data |
| sclk_o | output | 1 | Gated data clock |
| rts_o | output | 1 | Frame request line |
| strobe_o | output | 1 | First-bit strobe |
| busy_o | output | 1 | Transfer in progress |

## Verification
A tick held high for one cycle changes the sequencer at the next edge, and the pin registers copy it at the edge after that. The bench therefore drops the tick, waits one more falling edge, and only then compares every pin against values computed from the tick count. A load is checked in the same way, two edges later. Random gaps of idle cycles between ticks confirm that the pins hold their values until the next tick. Loads issued while busy, and ticks issued while idle, are checked at that same point by reading the data that comes out next and the state of `busy_o`.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic gated;     // clock toggles during data bits
        logic idle_lvl;  // resting level of the clock line
        logic act_rise;  // capture edge is rising
        logic framing;   // request and strobe lines are live
    } pin_cfg_t;

    localparam logic [1:0] SEL_EXPAND = 2'b11;
    localparam logic [1:0] SEL_OFF    = 2'b00;

    function automatic pin_cfg_t decode_cfg(
        input logic       sync_en,
        input logic [1:0] sel,
        input logic       idle_hi,
        input logic       rise_act
    );
        pin_cfg_t c;
        if (!sync_en) begin
            c.gated    = (sel == SEL_EXPAND);
            c.idle_lvl = 1'b1;
            c.act_rise = 1'b1;
            c.framing  = 1'b0;
        end else begin
            c.gated    = (sel != SEL_OFF);
            c.idle_lvl = idle_hi;
            c.act_rise = rise_act;
            c.framing  = 1'b1;
        end
        return c;
    endfunction

    // level of the clock line inside a bit cell: launch half, then capture half
    function automatic logic half_level(input logic act_rise, input logic capture_half);
        return act_rise ? capture_half : ~capture_half;
    endfunction

endpackage

// File: rtl/sftx_mode_dec.sv
module sftx_mode_dec
    import sftx_pkg::*;
(
    input  logic       sync_en_i,
    input  logic [1:0] clk_sel_i,
    input  logic       clk_idle_hi_i,
    input  logic       clk_rise_act_i,
    output pin_cfg_t   cfg_o
);

    always_comb begin
        cfg_o = decode_cfg(sync_en_i, clk_sel_i, clk_idle_hi_i, clk_rise_act_i);
    end

    // R3: expansion code forces a high-idle, rising-capture clock
    always_comb begin
        if (!sync_en_i && clk_sel_i == SEL_EXPAND) begin
            p_expand_shape_r3: assert (cfg_o.gated && cfg_o.idle_lvl && cfg_o.act_rise);
        end
    end

endmodule

// File: rtl/sftx_seq.sv
module sftx_seq
    import sftx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             sending_o,
    output logic             busy_o,
    output logic             bit_o,
    output logic             capture_o,
    output logic             first_bit_o
);

    localparam int PHASES = 2 * WIDTH;
    localparam int PW     = $clog2(PHASES);
    localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

    seq_state_e       state_q;
    logic [PW-1:0]    ph_q;
    logic [WIDTH-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            shreg_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (load_i) begin
                        shreg_q <= data_i;
                        state_q <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (tick_i) begin
                        state_q <= ST_SEND;
                        ph_q    <= '0;
                    end
                end
                ST_SEND: begin
                    if (tick_i) begin
                        if (ph_q == LAST_PH) begin
                            state_q <= ST_IDLE;
                            ph_q    <= '0;
                        end else begin
                            ph_q <= ph_q + 1'b1;
                            if (ph_q[0]) begin
                                shreg_q <= shreg_q >> 1;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sending_o   = (state_q == ST_SEND);
    assign busy_o      = (state_q != ST_IDLE);
    assign bit_o       = shreg_q[0];
    assign capture_o   = ph_q[0];
    assign first_bit_o = (ph_q[PW-1:1] == '0);

    // R9: busy only starts from a load request
    p_busy_from_load_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(load_i));

    // R9: a load during a transfer leaves the word untouched
    p_ignore_load_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && load_i && !tick_i) |=> $stable(shreg_q));

    // R7: the frame closes only after the MSB capture half
    p_close_after_msb_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sending_o) |-> ($past(ph_q) == LAST_PH));

    // R10: phase advances only on a tick
    p_phase_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (sending_o && !tick_i) |=> ($stable(ph_q) && sending_o));

endmodule

// File: rtl/sftx_pins.sv
module sftx_pins
    import sftx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg_i,
    input  logic     rts_hi_i,
    input  logic     sending_i,
    input  logic     busy_i,
    input  logic     bit_i,
    input  logic     capture_i,
    input  logic     first_bit_i,
    output logic     sdata_o,
    output logic     sclk_o,
    output logic     rts_o,
    output logic     strobe_o,
    output logic     busy_o
);

    logic sdata_d, sclk_d, rts_d, strobe_d;

    always_comb begin
        sdata_d  = sending_i ? bit_i : 1'b1;
        sclk_d   = (sending_i && cfg_i.gated) ? half_level(cfg_i.act_rise, capture_i)
                                              : cfg_i.idle_lvl;
        rts_d    = (cfg_i.framing && sending_i) ? rts_hi_i : ~rts_hi_i;
        strobe_d = cfg_i.framing && sending_i && first_bit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdata_o  <= 1'b1;
            sclk_o   <= 1'b1;
            rts_o    <= 1'b0;
            strobe_o <= 1'b0;
            busy_o   <= 1'b0;
        end else begin
            sdata_o  <= sdata_d;
            sclk_o   <= sclk_d;
            rts_o    <= rts_d;
            strobe_o <= strobe_d;
            busy_o   <= busy_i;
        end
    end

    // R8: the strobe never appears outside a transfer
    p_strobe_in_xfer_r8: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> busy_o);

    // R2: clock rests at its idle level when no bit was on the wire
    p_clk_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sending_i)) |-> (sclk_o == $past(cfg_i.idle_lvl)));

    // R1: the data line marks high between frames
    p_mark_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sending_i)) |-> sdata_o);

endmodule

// File: rtl/sync_frame_tx.sv
module sync_frame_tx
    import sftx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             sync_en_i,
    input  logic [1:0]       clk_sel_i,
    input  logic             clk_idle_hi_i,
    input  logic             clk_rise_act_i,
    input  logic             rts_hi_i,
    output logic             sdata_o,
    output logic             sclk_o,
    output logic             rts_o,
    output logic             strobe_o,
    output logic             busy_o
);

    pin_cfg_t cfg;
    logic     sending, busy_int, cur_bit, capture, first_bit;

    sftx_mode_dec u_dec (
        .sync_en_i      (sync_en_i),
        .clk_sel_i      (clk_sel_i),
        .clk_idle_hi_i  (clk_idle_hi_i),
        .clk_rise_act_i (clk_rise_act_i),
        .cfg_o          (cfg)
    );

    sftx_seq #(.WIDTH(WIDTH)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (bit_tick_i),
        .load_i      (load_i),
        .data_i      (data_i),
        .sending_o   (sending),
        .busy_o      (busy_int),
        .bit_o       (cur_bit),
        .capture_o   (capture),
        .first_bit_o (first_bit)
    );

    sftx_pins u_pins (
        .clk         (clk),
        .rst         (rst),
        .cfg_i       (cfg),
        .rts_hi_i    (rts_hi_i),
        .sending_i   (sending),
        .busy_i      (busy_int),
        .bit_i       (cur_bit),
        .capture_i   (capture),
        .first_bit_i (first_bit),
        .sdata_o     (sdata_o),
        .sclk_o      (sclk_o),
        .rts_o       (rts_o),
        .strobe_o    (strobe_o),
        .busy_o      (busy_o)
    );

    // R7: in synchronous mode the strobe sits inside an active request
    p_strobe_under_rts_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && sync_en_i && $stable(rts_hi_i)) |-> (rts_o == rts_hi_i));

endmodule

// File: tb/sync_frame_tx_test.sv
module sync_frame_tx_test;

    localparam int W      = 8;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0, load = 1'b0;
    logic [W-1:0] data = '0;
    logic         sync_en = 1'b0;
    logic [1:0]   sel = 2'b11;
    logic         idle_hi = 1'b1, rise = 1'b1, rts_hi = 1'b1;
    logic         sdata, sclk, rts, strobe, busy;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    sync_frame_tx #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .bit_tick_i(tick), .load_i(load), .data_i(data),
        .sync_en_i(sync_en), .clk_sel_i(sel), .clk_idle_hi_i(idle_hi),
        .clk_rise_act_i(rise), .rts_hi_i(rts_hi),
        .sdata_o(sdata), .sclk_o(sclk), .rts_o(rts), .strobe_o(strobe), .busy_o(busy)
    );

    // expected clock level per R2..R6
    function automatic logic exp_clk(logic sending, logic capture);
        if (!sync_en) begin
            if (sel == 2'b11) return sending ? capture : 1'b1;
            return 1'b1;
        end
        if (sel == 2'b00 || !sending) return idle_hi;
        return rise ? capture : ~capture;
    endfunction

    function automatic logic exp_rts(logic sending);
        return (sync_en && sending) ? rts_hi : ~rts_hi;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(string req, logic exp_busy);
        chk(req, "sdata idle", sdata, 1'b1);
        chk(req, "sclk idle", sclk, exp_clk(1'b0, 1'b0));
        chk(req, "rts idle", rts, exp_rts(1'b0));
        chk(req, "strobe idle", strobe, 1'b0);
        chk(req, "busy", busy, exp_busy);
    endtask

    // pulse one tick, then sample two edges after it (R10)
    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic gap(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(logic [W-1:0] word, bit busy_load, bit rnd_gap);
        logic [W-1:0] junk;
        @(negedge clk);
        gap(1);
        chk_idle("R2", 1'b0);
        // R10: a tick while idle changes nothing
        do_tick();
        chk_idle("R10", 1'b0);
        @(negedge clk) begin load = 1'b1; data = word; end
        @(negedge clk) begin load = 1'b0; data = ~word; end
        @(negedge clk);
        // armed, not yet sending: clock still idle (R2), busy up (R9)
        chk_idle("R9", 1'b1);
        if (busy_load) begin
            junk = ~word;
            @(negedge clk) begin load = 1'b1; data = junk; end
            @(negedge clk) load = 1'b0;
            @(negedge clk);
            chk("R9", "busy after ignored load", busy, 1'b1);
        end
        for (int ph = 0; ph < 2 * W; ph++) begin
            do_tick();
            chk("R1", $sformatf("sdata ph%0d", ph), sdata, word[ph/2]);
            chk(sync_en ? (sel == 2'b00 ? "R5" : "R4") : (sel == 2'b11 ? "R3" : "R6"),
                $sformatf("sclk ph%0d", ph), sclk, exp_clk(1'b1, ph[0]));
            chk("R7", $sformatf("rts ph%0d", ph), rts, exp_rts(1'b1));
            chk("R8", $sformatf("strobe ph%0d", ph), strobe, sync_en && (ph < 2));
            chk("R9", $sformatf("busy ph%0d", ph), busy, 1'b1);
            if (rnd_gap) begin
                gap($urandom_range(0, 2));
                chk("R10", $sformatf("sclk hold ph%0d", ph), sclk, exp_clk(1'b1, ph[0]));
            end
        end
        // R11: exactly 2*W ticks closes the frame
        do_tick();
        chk_idle("R11", 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1701));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        gap(2);
        chk_idle("R1", 1'b0);

        // expansion mode, directed
        sync_en = 1'b0; sel = 2'b11;
        run_frame(8'hA5, 1'b0, 1'b0);
        run_frame(8'h01, 1'b1, 1'b0);
        // non-expansion code with sync off: clock held high (R6)
        sel = 2'b01;
        run_frame(8'h3C, 1'b0, 1'b0);
        // synchronous, clock off (R5)
        sync_en = 1'b1; sel = 2'b00; idle_hi = 1'b0; rise = 1'b1; rts_hi = 1'b0;
        run_frame(8'h80, 1'b0, 1'b0);
        // synchronous, falling capture, high idle
        sel = 2'b10; idle_hi = 1'b1; rise = 1'b0; rts_hi = 1'b1;
        run_frame(8'hFF, 1'b1, 1'b1);
        run_frame(8'h00, 1'b0, 1'b0);

        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            sync_en = 1'($urandom_range(0, 1));
            sel     = 2'($urandom_range(0, 3));
            idle_hi = 1'($urandom_range(0, 1));
            rise    = 1'($urandom_range(0, 1));
            rts_hi  = 1'($urandom_range(0, 1));
            run_frame(W'($urandom), 1'($urandom_range(0, 1)), 1'b1);
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule